// File: doc/BRIEF.md
# Shadowed Configuration Register Bank

This block holds a set of byte-wide configuration registers that a rendering datapath needs all at once, every cycle. Each register lives in a flip-flop, and the whole set is presented as one wide parallel bus. A host port writes and reads the registers one byte at a time by address.

A host read is not served by a multiplexer over the flip-flops. Every host write also lands in a small distributed RAM at an index derived from the address, and host reads are answered from that RAM copy. Two address windows are covered. The main window of 26 registers maps into a 32-entry RAM. A second window of 8 registers maps into the upper half of a 16-entry RAM. The lower half of that RAM holds a further 8 registers that have no flip-flop copy. The datapath reads those through a separate index port.

Both copies start from the same per-window initial-value parameters, so they agree from power-up onward. Host reads of any other address pass through to an external read path.

Top module: `shadow_regfile`

## Requirements
- R1: A host write to an address in main window A (A_BASE up to A_BASE+A_COUNT-1, default 0x2804..0x281D) sets byte (address - A_BASE) of `cfg_a` (bits 8*k+7..8*k) to the written byte. The new value is visible on the cycle after the write.
- R2: A host write to an address in window B (B_BASE up to B_BASE+B_HALF-1, default 0x28C0..0x28C7) sets byte (address - B_BASE) of `cfg_b`. The new value is visible on the cycle after the write.
- R3: `host_rvalid` is high exactly on the cycle after a cycle with `host_rd` high. For a read of a window A or window B address, `host_rdata` then carries the current register value, which equals the flip-flop byte, and `host_rhit` is 1.
- R4: When no write has been made, every register reads back its initial value from the INIT_A, INIT_B or INIT_D parameter (entry k in bits 8*k+7..8*k), and `cfg_a` and `cfg_b` equal INIT_A and INIT_B.
- R5: Writes to the direct window (D_BASE up to D_BASE+B_HALF-1, default 0x28D0..0x28D7) go to the lower half of RAM B only. They are readable by the host with `host_rhit` at 1, and they leave `cfg_a` and `cfg_b` unchanged. Window B occupies the upper half: index bit 3 of RAM B is 1.
- R6: `dir_data` shows, combinationally, the direct-window register selected by `dir_idx`.
- R7: A host read of an address outside all three windows returns the `ext_rdata` value present in the read cycle, with `host_rhit` at 0.
- R8: A host write to an address outside the windows changes neither `cfg_a`, `cfg_b` nor any value read back from a window.
- R9: A read and a write to the same address in the same cycle return the value held before that write. The write still takes effect.
- R10: While `rst_n` is low, `host_rvalid` is 0. Register contents are not altered by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the read port |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | ADDR_W | Host byte address |
| host_wdata | input | DATA_W | Host write data |
| ext_rdata | input | DATA_W | Read data for addresses outside the windows |
| host_rdata | output | DATA_W | Registered read data |
| host_rvalid | output | 1 | Read data valid, one cycle after `host_rd` |
| host_rhit | output | 1 | The returned read hit a window |
| cfg_a | output | A_COUNT*DATA_W | Parallel flip-flop copy of window A |
| cfg_b | output | B_HALF*DATA_W | Parallel flip-flop copy of window B |
| dir_idx | input | clog2(B_HALF) | Datapath index into the direct window |
| dir_data | output | DATA_W | Direct-window register at `dir_idx` |

## Verification
The bench builds the block with the default window geometry and the RAM read variant selected (SHADOW_READ = 1). It overrides INIT_A, INIT_B and INIT_D with distinct non-zero patterns, one value per entry. With those values, a read that hits the wrong RAM index, or the wrong half of RAM B, cannot return a plausible value. A mismatch between the flip-flop and RAM start-up values also shows on the first readback. The default 32-entry RAM leaves six unmapped entries above window A, and writes aimed just past each window edge exercise those gaps.

// File: rtl/shreg_pkg.sv
package shreg_pkg;
   typedef enum logic [1:0] {
      SRC_EXT   = 2'd0,
      SRC_WIN_A = 2'd1,
      SRC_WIN_B = 2'd2
   } rd_src_e;
endpackage

// File: rtl/shreg_decode.sv
module shreg_decode
   import shreg_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter logic [ADDR_W-1:0] A_BASE = 16'h2804,
   parameter int A_COUNT = 26,
   parameter int A_IDX_W = 5,
   parameter logic [ADDR_W-1:0] B_BASE = 16'h28C0,
   parameter logic [ADDR_W-1:0] D_BASE = 16'h28D0,
   parameter int B_HALF  = 8,
   parameter int B_IDX_W = 4
) (
   input  logic [ADDR_W-1:0]  addr,
   output logic               in_a,
   output logic               in_b,
   output logic               in_d,
   output logic [A_IDX_W-1:0] a_idx,
   output logic [B_IDX_W-1:0] b_idx,
   output rd_src_e            src
);
   logic [ADDR_W-1:0] off_a, off_b, off_d;

   always_comb begin
      off_a = addr - A_BASE;
      off_b = addr - B_BASE;
      off_d = addr - D_BASE;
      in_a  = off_a < ADDR_W'(A_COUNT);
      in_b  = off_b < ADDR_W'(B_HALF);
      in_d  = off_d < ADDR_W'(B_HALF);
      a_idx = off_a[A_IDX_W-1:0];
      // top bit of the RAM B index picks the half: 1 = window B, 0 = direct
      b_idx = in_b ? {1'b1, off_b[B_IDX_W-2:0]} : {1'b0, off_d[B_IDX_W-2:0]};
      if (in_a)              src = SRC_WIN_A;
      else if (in_b || in_d) src = SRC_WIN_B;
      else                   src = SRC_EXT;
   end
endmodule

// File: rtl/shreg_flops.sv
module shreg_flops #(
   parameter int N     = 26,
   parameter int W     = 8,
   parameter int IDX_W = 5,
   parameter logic [N*W-1:0] INIT = '0
) (
   input  logic             clk,
   input  logic             we,
   input  logic [IDX_W-1:0] idx,
   input  logic [W-1:0]     wdata,
   output logic [N*W-1:0]   q
);
   for (genvar g = 0; g < N; g++) begin : g_reg
      logic [W-1:0] r = INIT[g*W +: W];
      always_ff @(posedge clk) begin
         if (we && idx == IDX_W'(g)) r <= wdata;
      end
      assign q[g*W +: W] = r;
   end
endmodule

// File: rtl/shreg_ram.sv
module shreg_ram #(
   parameter int DEPTH = 32,
   parameter int W     = 8,
   parameter int AW    = 5,
   parameter int RD_N  = 1,
   parameter logic [DEPTH*W-1:0] INIT = '0
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [W-1:0]      wdata,
   input  logic [RD_N*AW-1:0] raddr,
   output logic [RD_N*W-1:0]  rdata
);
   logic [W-1:0] mem [DEPTH];

   initial begin
      for (int i = 0; i < DEPTH; i++) mem[i] = INIT[i*W +: W];
   end

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   for (genvar p = 0; p < RD_N; p++) begin : g_rd
      assign rdata[p*W +: W] = mem[raddr[p*AW +: AW]];
   end
endmodule

// File: rtl/shadow_regfile.sv
module shadow_regfile
   import shreg_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 8,
   parameter logic [ADDR_W-1:0] A_BASE = 16'h2804,
   parameter int A_COUNT     = 26,
   parameter int RAM_A_DEPTH = 32,
   parameter logic [ADDR_W-1:0] B_BASE = 16'h28C0,
   parameter logic [ADDR_W-1:0] D_BASE = 16'h28D0,
   parameter int B_HALF      = 8,
   parameter bit SHADOW_READ = 1'b1,
   parameter logic [A_COUNT*DATA_W-1:0] INIT_A = '0,
   parameter logic [B_HALF*DATA_W-1:0]  INIT_B = '0,
   parameter logic [B_HALF*DATA_W-1:0]  INIT_D = '0
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        host_wr,
   input  logic                        host_rd,
   input  logic [ADDR_W-1:0]           host_addr,
   input  logic [DATA_W-1:0]           host_wdata,
   input  logic [DATA_W-1:0]           ext_rdata,
   output logic [DATA_W-1:0]           host_rdata,
   output logic                        host_rvalid,
   output logic                        host_rhit,
   output logic [A_COUNT*DATA_W-1:0]   cfg_a,
   output logic [B_HALF*DATA_W-1:0]    cfg_b,
   input  logic [$clog2(B_HALF)-1:0]   dir_idx,
   output logic [DATA_W-1:0]           dir_data
);
   localparam int A_IDX_W = $clog2(RAM_A_DEPTH);
   localparam int B_DEPTH = 2 * B_HALF;
   localparam int B_IDX_W = $clog2(B_DEPTH);
   localparam int D_IDX_W = $clog2(B_HALF);
   localparam logic [RAM_A_DEPTH*DATA_W-1:0] RAM_A_INIT = (RAM_A_DEPTH*DATA_W)'(INIT_A);
   localparam logic [B_DEPTH*DATA_W-1:0]     RAM_B_INIT = {INIT_B, INIT_D};

   if (A_COUNT > RAM_A_DEPTH) begin : g_chk_depth
      $error("window A does not fit in RAM A");
   end
   if (B_HALF != (1 << D_IDX_W) || B_HALF < 2) begin : g_chk_half
      $error("B_HALF must be a power of two of at least 2");
   end

   logic               in_a, in_b, in_d;
   logic [A_IDX_W-1:0] a_idx;
   logic [B_IDX_W-1:0] b_idx;
   rd_src_e            src;

   shreg_decode #(
      .ADDR_W(ADDR_W), .A_BASE(A_BASE), .A_COUNT(A_COUNT), .A_IDX_W(A_IDX_W),
      .B_BASE(B_BASE), .D_BASE(D_BASE), .B_HALF(B_HALF), .B_IDX_W(B_IDX_W)
   ) u_dec (
      .addr(host_addr), .in_a(in_a), .in_b(in_b), .in_d(in_d),
      .a_idx(a_idx), .b_idx(b_idx), .src(src)
   );

   // parallel flip-flop copies for the datapath
   shreg_flops #(.N(A_COUNT), .W(DATA_W), .IDX_W(A_IDX_W), .INIT(INIT_A)) u_ff_a (
      .clk(clk), .we(host_wr && in_a), .idx(a_idx), .wdata(host_wdata), .q(cfg_a)
   );
   shreg_flops #(.N(B_HALF), .W(DATA_W), .IDX_W(D_IDX_W), .INIT(INIT_B)) u_ff_b (
      .clk(clk), .we(host_wr && in_b), .idx(b_idx[B_IDX_W-2:0]), .wdata(host_wdata), .q(cfg_b)
   );

   // RAM B: upper half shadows window B, lower half holds the direct window
   logic [2*DATA_W-1:0] ram_b_q;
   shreg_ram #(.DEPTH(B_DEPTH), .W(DATA_W), .AW(B_IDX_W), .RD_N(2), .INIT(RAM_B_INIT)) u_ram_b (
      .clk(clk), .we(host_wr && (in_b || in_d)), .waddr(b_idx), .wdata(host_wdata),
      .raddr({{1'b0, dir_idx}, b_idx}), .rdata(ram_b_q)
   );
   assign dir_data = ram_b_q[DATA_W +: DATA_W];

   logic [DATA_W-1:0] rd_a, rd_b;

   if (SHADOW_READ) begin : g_shadow
      shreg_ram #(.DEPTH(RAM_A_DEPTH), .W(DATA_W), .AW(A_IDX_W), .RD_N(1), .INIT(RAM_A_INIT)) u_ram_a (
         .clk(clk), .we(host_wr && in_a), .waddr(a_idx), .wdata(host_wdata),
         .raddr(a_idx), .rdata(rd_a)
      );
      assign rd_b = ram_b_q[DATA_W-1:0];
   end else begin : g_flopmux
      always_comb begin
         rd_a = '0;
         for (int i = 0; i < A_COUNT; i++)
            if (a_idx == A_IDX_W'(i)) rd_a = cfg_a[i*DATA_W +: DATA_W];
         rd_b = ram_b_q[DATA_W-1:0];
         if (in_b) begin
            for (int i = 0; i < B_HALF; i++)
               if (b_idx[B_IDX_W-2:0] == D_IDX_W'(i)) rd_b = cfg_b[i*DATA_W +: DATA_W];
         end
      end
   end

   logic [DATA_W-1:0] rd_byte;
   always_comb begin
      unique case (src)
         SRC_WIN_A: rd_byte = rd_a;
         SRC_WIN_B: rd_byte = rd_b;
         default:   rd_byte = ext_rdata;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         host_rvalid <= 1'b0;
         host_rhit   <= 1'b0;
         host_rdata  <= '0;
      end else begin
         host_rvalid <= host_rd;
         if (host_rd) begin
            host_rdata <= rd_byte;
            host_rhit  <= (src != SRC_EXT);
         end
      end
   end
endmodule

// File: rtl/shreg_chk.sv
module shreg_chk #(
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 8,
   parameter logic [ADDR_W-1:0] A_BASE = 16'h2804,
   parameter int A_COUNT = 26,
   parameter logic [ADDR_W-1:0] B_BASE = 16'h28C0,
   parameter logic [ADDR_W-1:0] D_BASE = 16'h28D0,
   parameter int B_HALF  = 8
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      host_wr,
   input logic                      host_rd,
   input logic [ADDR_W-1:0]         host_addr,
   input logic [DATA_W-1:0]         host_wdata,
   input logic [DATA_W-1:0]         ext_rdata,
   input logic [DATA_W-1:0]         host_rdata,
   input logic                      host_rvalid,
   input logic                      host_rhit,
   input logic [A_COUNT*DATA_W-1:0] cfg_a,
   input logic [B_HALF*DATA_W-1:0]  cfg_b
);
   logic [ADDR_W-1:0] off_a, off_b, off_d;
   logic in_a, in_b, in_d;
   assign off_a = host_addr - A_BASE;
   assign off_b = host_addr - B_BASE;
   assign off_d = host_addr - D_BASE;
   assign in_a  = off_a < ADDR_W'(A_COUNT);
   assign in_b  = off_b < ADDR_W'(B_HALF);
   assign in_d  = off_d < ADDR_W'(B_HALF);

   logic              wr_a_q, wr_b_q, rd_sh_q, rd_ext_q;
   logic [ADDR_W-1:0] wr_off_q;
   logic [DATA_W-1:0] wr_data_q, rd_flop_q, ext_q;
   logic [DATA_W-1:0] fa_now, fb_now, sel_wa, sel_wb;

   always_comb begin
      fa_now = '0; fb_now = '0; sel_wa = '0; sel_wb = '0;
      for (int i = 0; i < A_COUNT; i++) begin
         if (off_a == ADDR_W'(i))    fa_now = cfg_a[i*DATA_W +: DATA_W];
         if (wr_off_q == ADDR_W'(i)) sel_wa = cfg_a[i*DATA_W +: DATA_W];
      end
      for (int i = 0; i < B_HALF; i++) begin
         if (off_b == ADDR_W'(i))    fb_now = cfg_b[i*DATA_W +: DATA_W];
         if (wr_off_q == ADDR_W'(i)) sel_wb = cfg_b[i*DATA_W +: DATA_W];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_a_q <= 1'b0; wr_b_q <= 1'b0; rd_sh_q <= 1'b0; rd_ext_q <= 1'b0;
         wr_off_q <= '0; wr_data_q <= '0; rd_flop_q <= '0; ext_q <= '0;
      end else begin
         wr_a_q    <= host_wr && in_a;
         wr_b_q    <= host_wr && in_b;
         wr_off_q  <= in_a ? off_a : off_b;
         wr_data_q <= host_wdata;
         rd_sh_q   <= host_rd && (in_a || in_b);
         rd_flop_q <= in_a ? fa_now : fb_now;
         rd_ext_q  <= host_rd && !(in_a || in_b || in_d);
         ext_q     <= ext_rdata;
      end
   end

   p_wr_a_r1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_a_q |-> sel_wa == wr_data_q);
   p_wr_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_b_q |-> sel_wb == wr_data_q);
   p_rd_flop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_sh_q |-> host_rvalid && host_rhit && host_rdata == rd_flop_q);
   p_rd_ext_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ext_q |-> host_rvalid && !host_rhit && host_rdata == ext_q);
   p_wr_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && !(in_a || in_b)) |=> $stable(cfg_a) && $stable(cfg_b));
   p_rvalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
      host_rvalid |-> $past(host_rd));
endmodule

bind shadow_regfile shreg_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .A_BASE(A_BASE), .A_COUNT(A_COUNT),
   .B_BASE(B_BASE), .D_BASE(D_BASE), .B_HALF(B_HALF)
) u_chk (
   .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
   .host_addr(host_addr), .host_wdata(host_wdata), .ext_rdata(ext_rdata),
   .host_rdata(host_rdata), .host_rvalid(host_rvalid), .host_rhit(host_rhit),
   .cfg_a(cfg_a), .cfg_b(cfg_b)
);

// File: tb/shadow_regfile_tb_top.sv
`timescale 1ns/1ps
module shadow_regfile_tb_top;
   localparam int NA = 26;
   localparam int NB = 8;

   function automatic logic [NA*8-1:0] mk_a();
      logic [NA*8-1:0] v;
      for (int i = 0; i < NA; i++) v[i*8 +: 8] = 8'(i*37 + 5);
      return v;
   endfunction
   function automatic logic [NB*8-1:0] mk_b(input logic [7:0] base);
      logic [NB*8-1:0] v;
      for (int i = 0; i < NB; i++) v[i*8 +: 8] = base + 8'(i*3);
      return v;
   endfunction

   localparam logic [NA*8-1:0] IA = mk_a();
   localparam logic [NB*8-1:0] IB = mk_b(8'hA1);
   localparam logic [NB*8-1:0] ID = mk_b(8'h52);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic host_wr = 1'b0, host_rd = 1'b0;
   logic [15:0] host_addr = '0;
   logic [7:0]  host_wdata = '0, ext_rdata = '0;
   logic [7:0]  host_rdata;
   logic        host_rvalid, host_rhit;
   logic [NA*8-1:0] cfg_a;
   logic [NB*8-1:0] cfg_b;
   logic [2:0]  dir_idx = '0;
   logic [7:0]  dir_data;

   always #4 clk = ~clk;

   shadow_regfile #(.INIT_A(IA), .INIT_B(IB), .INIT_D(ID)) dut_i (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
      .host_addr(host_addr), .host_wdata(host_wdata), .ext_rdata(ext_rdata),
      .host_rdata(host_rdata), .host_rvalid(host_rvalid), .host_rhit(host_rhit),
      .cfg_a(cfg_a), .cfg_b(cfg_b), .dir_idx(dir_idx), .dir_data(dir_data)
   );

   int checks = 0, errors = 0;
   bit done = 1'b0;
   logic [7:0] mA [NA];
   logic [7:0] mB [NB];
   logic [7:0] mD [NB];
   logic [8:0] exp_q [$];
   string      tag_q [$];

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   function automatic logic [8:0] exp_for(input logic [15:0] a, input logic [7:0] ext);
      logic [15:0] oa, ob, od;
      oa = a - 16'h2804; ob = a - 16'h28C0; od = a - 16'h28D0;
      if (oa < 16'd26) return {1'b1, mA[oa[4:0]]};
      if (ob < 16'd8)  return {1'b1, mB[ob[2:0]]};
      if (od < 16'd8)  return {1'b1, mD[od[2:0]]};
      return {1'b0, ext};
   endfunction

   task automatic model_wr(input logic [15:0] a, input logic [7:0] d);
      logic [15:0] oa, ob, od;
      oa = a - 16'h2804; ob = a - 16'h28C0; od = a - 16'h28D0;
      if (oa < 16'd26)     mA[oa[4:0]] = d;
      else if (ob < 16'd8) mB[ob[2:0]] = d;
      else if (od < 16'd8) mD[od[2:0]] = d;
   endtask

   task automatic check_cfg(input string tag);
      logic [NA*8-1:0] ea;
      logic [NB*8-1:0] eb;
      for (int i = 0; i < NA; i++) ea[i*8 +: 8] = mA[i];
      for (int i = 0; i < NB; i++) eb[i*8 +: 8] = mB[i];
      chk(cfg_a == ea, {tag, " cfg_a"}, cfg_a[31:0] ^ ea[31:0], 0);
      chk(cfg_b == eb, {tag, " cfg_b"}, cfg_b[31:0], eb[31:0]);
   endtask

   // driver tasks: called right after a falling edge
   task automatic do_write(input logic [15:0] a, input logic [7:0] d, input string tag);
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
      model_wr(a, d);
      check_cfg(tag);
   endtask

   task automatic do_read(input logic [15:0] a, input logic [7:0] ext, input string tag);
      host_rd = 1'b1; host_addr = a; ext_rdata = ext;
      exp_q.push_back(exp_for(a, ext)); tag_q.push_back(tag);
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic do_rw(input logic [15:0] a, input logic [7:0] d, input string tag);
      host_rd = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
      exp_q.push_back(exp_for(a, 8'h00)); tag_q.push_back(tag);
      @(negedge clk);
      host_rd = 1'b0; host_wr = 1'b0;
      model_wr(a, d);
      check_cfg(tag);
   endtask

   // monitor: compares returned reads against the scoreboard
   always @(negedge clk) begin
      if (rst_n && host_rvalid) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R3 unexpected rvalid", 32'(host_rdata), 0);
         end else begin
            logic [8:0] e;
            string t;
            e = exp_q.pop_front(); t = tag_q.pop_front();
            chk({host_rhit, host_rdata} == e, {t, " readback"}, 32'({host_rhit, host_rdata}), 32'(e));
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         chk(1'b0, "R3 watchdog expired", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NA; i++) mA[i] = IA[i*8 +: 8];
      for (int i = 0; i < NB; i++) begin mB[i] = IB[i*8 +: 8]; mD[i] = ID[i*8 +: 8]; end

      repeat (3) @(negedge clk);
      chk(host_rvalid == 1'b0, "R10 rvalid in reset", 32'(host_rvalid), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R4: initial values, no writes
      check_cfg("R4");
      for (int i = 0; i < NA; i++) do_read(16'h2804 + 16'(i), 8'h00, "R4 win A");
      for (int i = 0; i < NB; i++) do_read(16'h28C0 + 16'(i), 8'h00, "R4 win B");
      for (int i = 0; i < NB; i++) do_read(16'h28D0 + 16'(i), 8'h00, "R4 direct");

      // R6: datapath port into the direct window
      for (int i = 0; i < NB; i++) begin
         dir_idx = 3'(i); #1;
         chk(dir_data == mD[i], "R6 dir_data", 32'(dir_data), 32'(mD[i]));
      end

      // R1 / R2 window edges
      do_write(16'h2804, 8'h3C, "R1 low edge");
      do_write(16'h281D, 8'h5A, "R1 high edge");
      do_write(16'h28C0, 8'h96, "R2 low edge");
      do_write(16'h28C7, 8'h0F, "R2 high edge");
      do_read(16'h2804, 8'h00, "R3 A low");
      do_read(16'h281D, 8'h00, "R3 A high");
      do_read(16'h28C0, 8'h00, "R3 B low");
      do_read(16'h28C7, 8'h00, "R3 B high");

      // R5: direct window in the lower half of RAM B
      do_write(16'h28D3, 8'h77, "R5 direct write");
      do_read(16'h28D3, 8'h00, "R5 direct read");
      do_read(16'h28C3, 8'h00, "R5 win B untouched");
      dir_idx = 3'd3; #1;
      chk(dir_data == 8'h77, "R5 dir_data after write", 32'(dir_data), 32'h77);

      // R8: writes just outside every window
      do_write(16'h2803, 8'hEE, "R8 below A");
      do_write(16'h281E, 8'hEE, "R8 above A");
      do_write(16'h281F, 8'hEE, "R8 above A");
      do_write(16'h28BF, 8'hEE, "R8 below B");
      do_write(16'h28C8, 8'hEE, "R8 above B");
      do_write(16'h28CF, 8'hEE, "R8 below D");
      do_write(16'h28D8, 8'hEE, "R8 above D");
      do_write(16'h0000, 8'hEE, "R8 far");
      do_read(16'h281D, 8'h00, "R8 neighbour A");
      do_read(16'h28C7, 8'h00, "R8 neighbour B");

      // R7: pass-through reads
      do_read(16'h281E, 8'hC4, "R7 gap above A");
      do_read(16'h28CF, 8'h19, "R7 below D");
      do_read(16'hFFFF, 8'h6B, "R7 far");

      // R9: same-cycle read and write
      do_rw(16'h2810, 8'hE1, "R9 win A");
      do_read(16'h2810, 8'h00, "R9 after write");
      do_rw(16'h28C5, 8'h2D, "R9 win B");
      do_read(16'h28C5, 8'h00, "R9 after write B");

      // random traffic
      for (int n = 0; n < 120; n++) begin
         logic [15:0] a;
         int w;
         w = $urandom_range(0, 3);
         case (w)
            0: a = 16'h2802 + 16'($urandom_range(0, 29));
            1: a = 16'h28BE + 16'($urandom_range(0, 11));
            2: a = 16'h28CE + 16'($urandom_range(0, 11));
            default: a = 16'($urandom);
         endcase
         if (n % 2 == 0) do_write(a, 8'($urandom), "R1 random write");
         else            do_read(a, 8'($urandom), "R3 random read");
      end

      // full sweep against the model
      for (int i = 0; i < NA; i++) do_read(16'h2804 + 16'(i), 8'h00, "R3 sweep A");
      for (int i = 0; i < NB; i++) do_read(16'h28C0 + 16'(i), 8'h00, "R3 sweep B");
      for (int i = 0; i < NB; i++) do_read(16'h28D0 + 16'(i), 8'h00, "R5 sweep D");
      repeat (2) @(negedge clk);

      // R10: reset mid-run keeps contents
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk(host_rvalid == 1'b0, "R10 rvalid mid-run reset", 32'(host_rvalid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check_cfg("R10 after reset");
      do_read(16'h2810, 8'h00, "R10 readback");
      do_read(16'h28D3, 8'h00, "R10 direct readback");
      repeat (2) @(negedge clk);
      chk(exp_q.size() == 0, "R3 scoreboard drained", 32'(exp_q.size()), 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule